// File: doc/BRIEF.md
# E1 Receive Frame Pulse Generator

This block produces a one-bit timing reference for a single E1 receive channel. It runs on the recovered receive bit clock and tracks three positions. The first is a bit position inside the 256-bit frame. The other two are free-running 16-frame counts: one for the signaling multiframe and one for the CRC multiframe. An upstream framer realigns each count with a one-cycle strobe. A device that handles several channels uses one copy of the block per channel.

A two-bit mode input selects what the output shows:
- a pulse on the first bit of every frame;
- a pulse on the first bit of signaling multiframe frame 1;
- a pulse on the first bit of CRC multiframe frame 1;
- a composite level. It rises on the first bit of signaling frame 1 and falls after the first bit of CRC frame 1. Both multiframe phases can therefore be decoded from one wire.

A disable input holds the output low. All state, including the output register, changes on the falling edge of the bit clock.

Top module: `e1_rx_fpulse`

## Requirements
- R1: A synchronous active-high reset places the bit position at bit 1 and both multiframe counts at frame 1, and holds the output low. After reset is released, the first bit-clock falling edge moves the position to bit 2.
- R2: With mode 00 (frame), the output is high for exactly one bit-clock cycle per frame, during bit 1, once every 256 cycles.
- R3: With mode 01 (signaling multiframe), the output is high for one cycle, during bit 1 of signaling frame 1. This repeats every 16 frames whether or not the upstream framer has locked.
- R4: With mode 10 (CRC multiframe), the output is high for one cycle, during bit 1 of CRC frame 1. This repeats every 16 frames.
- R5: With mode 11 (composite), the output goes high at the start of bit 1 of signaling frame 1. It goes low at the end of bit 1 of CRC frame 1.
- R6: In composite mode, if the signaling and CRC frame-1 positions coincide, the output is a single one-cycle pulse every 16 frames.
- R7: A frame-alignment strobe makes the next cycle bit 1 of a frame, regardless of the current bit position.
- R8: A signaling or CRC alignment strobe makes the matching count read frame 1 from the next frame boundary on. The other count is left unchanged.
- R9: While the disable input is high, the output is low. The counters and the composite state keep running, so clearing disable shows the same phases as if it had never been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive bit clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Output style: 00 frame, 01 signaling MF, 10 CRC MF, 11 composite |
| out_dis | input | 1 | Forces the output low |
| frm_align | input | 1 | One-cycle strobe: next cycle is bit 1 |
| sig_align | input | 1 | One-cycle strobe: signaling count is frame 1 from the next frame boundary |
| crc_align | input | 1 | One-cycle strobe: CRC count is frame 1 from the next frame boundary |
| rfp_o | output | 1 | Receive frame pulse / composite multiframe level |

## Verification
In composite mode, setting and clearing the composite flag can both fall on the same bit. This happens when the signaling and CRC frame-1 positions coincide. The bench provokes the overlap by strobing both multiframe alignments in one cycle, then runs two full multiframes. Every cycle is compared against a scoreboard model, which expects exactly one high cycle per multiframe and never a stuck-high level.

// File: rtl/rfp_pkg.sv
`timescale 1ns/1ps
package rfp_pkg;
  typedef enum logic [1:0] {
    RFP_FRAME = 2'b00,
    RFP_SIGMF = 2'b01,
    RFP_CRCMF = 2'b10,
    RFP_COMP  = 2'b11
  } rfp_mode_e;

  localparam int RFP_NUM_MF = 2;
  localparam int RFP_SIG    = 0;
  localparam int RFP_CRC    = 1;
endpackage

// File: rtl/rfp_bit_ctr.sv
`timescale 1ns/1ps
module rfp_bit_ctr #(
  parameter int FRAME_BITS = 256,
  localparam int BW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align,
  output logic [BW-1:0] bit_q,
  output logic [BW-1:0] bit_nxt,
  output logic          frame_end
);
  localparam logic [BW-1:0] LAST = BW'(FRAME_BITS - 1);

  function automatic logic [BW-1:0] advance(input logic [BW-1:0] cur, input logic realign);
    if (realign || cur == LAST) return '0;
    return cur + 1'b1;
  endfunction

  assign frame_end = (bit_q == LAST);
  assign bit_nxt   = advance(bit_q, align);

  always_ff @(negedge clk) begin
    if (rst) bit_q <= '0;
    else     bit_q <= bit_nxt;
  end

  p_align_bit1_r7: assert property (@(negedge clk) disable iff (rst)
    align |=> (bit_q == '0));

  p_frame_wrap_r2: assert property (@(negedge clk) disable iff (rst)
    (frame_end && !align) |=> (bit_q == '0));
endmodule

// File: rtl/rfp_mf_ctr.sv
`timescale 1ns/1ps
module rfp_mf_ctr #(
  parameter int MF_FRAMES = 16,
  localparam int FW = $clog2(MF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align,
  input  logic          frame_end,
  output logic [FW-1:0] frm_q,
  output logic [FW-1:0] frm_nxt
);
  localparam logic [FW-1:0] LASTF = FW'(MF_FRAMES - 1);

  logic pend_q;
  logic load;

  function automatic logic [FW-1:0] step_frame(input logic [FW-1:0] cur);
    if (cur == LASTF) return '0;
    return cur + 1'b1;
  endfunction

  assign load    = frame_end && (align || pend_q);
  assign frm_nxt = load ? '0 : (frame_end ? step_frame(frm_q) : frm_q);

  always_ff @(negedge clk) begin
    if (rst) begin
      frm_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      frm_q  <= frm_nxt;
      pend_q <= frame_end ? 1'b0 : (pend_q || align);
    end
  end

  p_realign_r8: assert property (@(negedge clk) disable iff (rst)
    (frame_end && (align || pend_q)) |=> (frm_q == '0));

  p_hold_midframe_r8: assert property (@(negedge clk) disable iff (rst)
    !frame_end |=> $stable(frm_q));
endmodule

// File: rtl/rfp_out_stage.sv
`timescale 1ns/1ps
module rfp_out_stage
  import rfp_pkg::*;
#(
  parameter int BW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          dis,
  input  logic          frm_align,
  input  logic [BW-1:0] bit_q,
  input  logic [BW-1:0] bit_nxt,
  input  logic [FW-1:0] sig_q,
  input  logic [FW-1:0] sig_nxt,
  input  logic [FW-1:0] crc_q,
  input  logic [FW-1:0] crc_nxt,
  output logic          out_q
);
  logic comp_q, comp_nxt, comp_set, comp_clr, out_nxt;
  rfp_mode_e md;

  function automatic logic mark(input logic [BW-1:0] b, input logic [FW-1:0] f);
    return (b == '0) && (f == '0);
  endfunction

  assign md = rfp_mode_e'(mode);

  always_comb begin
    comp_set = mark(bit_nxt, sig_nxt);
    comp_clr = mark(bit_q, crc_q);
    if (comp_set)      comp_nxt = 1'b1;
    else if (comp_clr) comp_nxt = 1'b0;
    else               comp_nxt = comp_q;
    unique case (md)
      RFP_FRAME: out_nxt = (bit_nxt == '0);
      RFP_SIGMF: out_nxt = mark(bit_nxt, sig_nxt);
      RFP_CRCMF: out_nxt = mark(bit_nxt, crc_nxt);
      default:   out_nxt = comp_nxt;
    endcase
    if (dis) out_nxt = 1'b0;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      comp_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      comp_q <= comp_nxt;
      out_q  <= out_nxt;
    end
  end

  p_disable_low_r9: assert property (@(negedge clk) disable iff (rst)
    dis |=> !out_q);

  p_single_cycle_r2: assert property (@(negedge clk) disable iff (rst)
    (out_q && !frm_align && md != RFP_COMP && $stable(mode)) |=> !out_q);

  p_sig_position_r3: assert property (@(negedge clk) disable iff (rst)
    (out_q && md == RFP_SIGMF && $stable(mode)) |-> (bit_q == '0 && sig_q == '0));

  p_crc_position_r4: assert property (@(negedge clk) disable iff (rst)
    (out_q && md == RFP_CRCMF && $stable(mode)) |-> (bit_q == '0 && crc_q == '0));

  p_comp_fall_r5: assert property (@(negedge clk) disable iff (rst)
    (md == RFP_COMP && bit_q == '0 && crc_q == '0 && !comp_set) |=> !out_q);
endmodule

// File: rtl/e1_rx_fpulse.sv
`timescale 1ns/1ps
module e1_rx_fpulse
  import rfp_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16
) (
  input  logic       rx_clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       out_dis,
  input  logic       frm_align,
  input  logic       sig_align,
  input  logic       crc_align,
  output logic       rfp_o
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(MF_FRAMES);

  logic [BW-1:0] bit_q, bit_nxt;
  logic          frame_end;
  logic [RFP_NUM_MF-1:0] mf_align;
  logic [FW-1:0] frm_q   [RFP_NUM_MF];
  logic [FW-1:0] frm_nxt [RFP_NUM_MF];

  assign mf_align[RFP_SIG] = sig_align;
  assign mf_align[RFP_CRC] = crc_align;

  rfp_bit_ctr #(.FRAME_BITS(FRAME_BITS)) u_bit (
    .clk(rx_clk), .rst(rst), .align(frm_align),
    .bit_q(bit_q), .bit_nxt(bit_nxt), .frame_end(frame_end)
  );

  for (genvar g = 0; g < RFP_NUM_MF; g++) begin : g_mf
    rfp_mf_ctr #(.MF_FRAMES(MF_FRAMES)) u_mf (
      .clk(rx_clk), .rst(rst), .align(mf_align[g]), .frame_end(frame_end),
      .frm_q(frm_q[g]), .frm_nxt(frm_nxt[g])
    );
  end

  rfp_out_stage #(.BW(BW), .FW(FW)) u_out (
    .clk(rx_clk), .rst(rst), .mode(mode_sel), .dis(out_dis),
    .frm_align(frm_align),
    .bit_q(bit_q), .bit_nxt(bit_nxt),
    .sig_q(frm_q[RFP_SIG]), .sig_nxt(frm_nxt[RFP_SIG]),
    .crc_q(frm_q[RFP_CRC]), .crc_nxt(frm_nxt[RFP_CRC]),
    .out_q(rfp_o)
  );
endmodule

// File: tb/test_e1_rx_fpulse.sv
`timescale 1ns/1ps
module test_e1_rx_fpulse;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic out_dis = 1'b0, frm_align = 1'b0, sig_align = 1'b0, crc_align = 1'b0;
  logic rfp_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    exp_q[$];
  string req_q[$];
  string cur_req = "R1";

  // bench model state
  int mb = 0, ms = 0, mc = 0;
  bit mps = 0, mpc = 0, mcomp = 0;

  e1_rx_fpulse i_e1_rx_fpulse (
    .rx_clk(clk), .rst(rst), .mode_sel(mode_sel), .out_dis(out_dis),
    .frm_align(frm_align), .sig_align(sig_align), .crc_align(crc_align),
    .rfp_o(rfp_o)
  );

  always #2 clk = ~clk;

  task automatic step(input bit r, input logic [1:0] m, input bit d,
                      input bit fa, input bit sa, input bit ca);
    bit e;
    @(posedge clk);
    rst = r; mode_sel = m; out_dis = d;
    frm_align = fa; sig_align = sa; crc_align = ca;
    if (r) begin
      mb = 0; ms = 0; mc = 0; mps = 0; mpc = 0; mcomp = 0; e = 0;
    end else begin
      bit fe, ncomp;
      int nb, ns, nc;
      fe = (mb == 255);
      nb = (fa || fe) ? 0 : mb + 1;
      ns = fe ? ((sa || mps) ? 0 : (ms + 1) % 16) : ms;
      nc = fe ? ((ca || mpc) ? 0 : (mc + 1) % 16) : mc;
      if (nb == 0 && ns == 0)      ncomp = 1;
      else if (mb == 0 && mc == 0) ncomp = 0;
      else                         ncomp = mcomp;
      case (m)
        2'b00:   e = (nb == 0);
        2'b01:   e = (nb == 0 && ns == 0);
        2'b10:   e = (nb == 0 && nc == 0);
        default: e = ncomp;
      endcase
      if (d) e = 0;
      mps = fe ? 0 : (mps || sa);
      mpc = fe ? 0 : (mpc || ca);
      mb = nb; ms = ns; mc = nc; mcomp = ncomp;
    end
    exp_q.push_back(e);
    req_q.push_back(cur_req);
  endtask

  task automatic run(input int n, input logic [1:0] m, input bit d);
    for (int i = 0; i < n; i++) step(1'b0, m, d, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: compares after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        checks++;
        if (rfp_o !== e) begin
          errors++;
          $display("FAIL %s: rfp_o=%b expected %b at %0t", rq, rfp_o, e, $time);
        end
      end
    end
  end

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    run(20, 2'b00, 1'b0);
    cur_req = "R2";
    run(600, 2'b00, 1'b0);
    cur_req = "R8";
    run(100, 2'b01, 1'b0);
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
    run(300, 2'b01, 1'b0);
    cur_req = "R3";
    run(8192, 2'b01, 1'b0);
    cur_req = "R8";
    run(5 * 256, 2'b10, 1'b0);
    step(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_req = "R4";
    run(8192, 2'b10, 1'b0);
    cur_req = "R5";
    run(8192, 2'b11, 1'b0);
    cur_req = "R6";
    step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1);
    run(8192, 2'b11, 1'b0);
    cur_req = "R7";
    run(77, 2'b00, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    run(600, 2'b00, 1'b0);
    cur_req = "R8";
    step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0);
    run(3 * 256, 2'b11, 1'b0);
    cur_req = "R9";
    run(1000, 2'b00, 1'b1);
    run(5000, 2'b11, 1'b1);
    run(5000, 2'b11, 1'b0);
    run(600, 2'b00, 1'b0);
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule